// File: doc/BRIEF.md
# Accumulator ALU with Rotates

This block is the arithmetic core of a small accumulator machine. The accumulator value, a second operand, the current flag set and an operation select go in. The new accumulator value and four updated condition flags come out in the same cycle. The second operand may come from a register, a memory byte or an immediate; the block does not care which. Two kinds of operation are offered:

- eight two-operand functions, chosen by a 3-bit code;
- four single-bit accumulator rotates, chosen by a 2-bit code.

The rotates come as two pairs. In one pair the bit shifted out is copied both into carry and into the vacated end. In the other pair the bits pass through carry.

A condition evaluator tests a 3-bit condition field against the current flags, for use by conditional jumps, calls and returns. The datapath is combinational. When `REG_FLAGS` is 1, a registered copy of the new flags is added. It has a write enable, and its output can be looped back to `flags_in` by the surrounding sequencer. When `REG_FLAGS` is 0, the new flags pass straight through to `flags_q`. Instruction fetch, register storage, memory access and sequencing belong to the surrounding machine.

Top module: `accum_alu`

## Requirements
- R1: With `is_rot`=0, `alu_code` selects the function: 000 add, 001 add with carry-in, 010 subtract, 011 subtract with borrow-in. The result is written to `acc_out` and wraps modulo 2^WIDTH.
- R2: Codes 100 AND, 101 XOR and 110 OR write the bitwise result to `acc_out` and always clear carry.
- R3: Code 111 compares the two operands. It sets the flags exactly as subtract would, and `acc_out` equals `acc_in` unchanged.
- R4: After an add, carry is the carry out of bit WIDTH-1. After a subtract or compare, carry is the borrow. Carry-in and borrow-in are taken from `flags_in[0]`.
- R5: The flag vectors are laid out as bit 3 sign, bit 2 zero, bit 1 parity, bit 0 carry. After a two-operand function:
  - zero is set when the WIDTH-bit result is 0;
  - sign is result bit WIDTH-1;
  - parity is set when the result holds an even number of ones.
- R6: With `is_rot`=1 and `rot_sel`=00, the accumulator rotates left. Old bit WIDTH-1 goes to both bit 0 and carry. With `rot_sel`=01 it rotates right, and old bit 0 goes to both bit WIDTH-1 and carry.
- R7: With `rot_sel`=10 the accumulator rotates left through carry: old bit WIDTH-1 goes to carry and the old carry goes to bit 0. With `rot_sel`=11 it rotates right through carry: old bit 0 goes to carry and the old carry goes to bit WIDTH-1.
- R8: A rotate changes only carry. The sign, zero and parity outputs equal those bits of `flags_in`.
- R9: `cond_true` is `cond_code[2]` XNOR a selected flag of `flags_in`. `cond_code[1:0]` selects the flag: 00 carry, 01 zero, 10 sign, 11 parity.
- R10: With REG_FLAGS=1, `flags_q` is cleared by synchronous reset. It loads `flags_new` on a clock edge where `flag_we` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional flag register |
| rst | input | 1 | Synchronous active-high reset |
| is_rot | input | 1 | 1 selects a rotate, 0 a two-operand function |
| alu_code | input | 3 | Two-operand function select |
| rot_sel | input | 2 | Rotate select |
| acc_in | input | WIDTH | Current accumulator |
| opnd_in | input | WIDTH | Second operand |
| flags_in | input | 4 | Current flags {sign, zero, parity, carry} |
| cond_code | input | 3 | Condition field to evaluate |
| flag_we | input | 1 | Load enable for the flag register |
| acc_out | output | WIDTH | New accumulator value |
| flags_new | output | 4 | Updated flags {sign, zero, parity, carry} |
| flags_q | output | 4 | Registered flags (or `flags_new` when REG_FLAGS=0) |
| cond_true | output | 1 | Condition evaluates true |

## Verification
The bench builds the block with its defaults, WIDTH=8 and REG_FLAGS=1. At eight bits, values such as 0xFF, 0x80 and 0x00 hit every carry, borrow, sign-edge and wrap corner directly, and the condition evaluator can be swept over all 8 codes against all 16 flag patterns. Having the register built puts reset clearing, enabled load and disabled hold within reach through `flags_q`. The pass-through variant is not built by the bench.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ROT_LEFT_COPY  = 2'd0,
        ROT_RIGHT_COPY = 2'd1,
        ROT_LEFT_THRU  = 2'd2,
        ROT_RIGHT_THRU = 2'd3
    } rot_e;

    typedef struct packed {
        logic sg;
        logic zr;
        logic pe;
        logic cy;
    } flags_t;

    localparam int FLAG_BITS = $bits(flags_t);

    // pick the flag named by the low two bits of a condition field
    function automatic logic pick_flag(input flags_t f, input logic [1:0] sel);
        logic v;
        case (sel)
            2'd0:    v = f.cy;
            2'd1:    v = f.zr;
            2'd2:    v = f.sg;
            default: v = f.pe;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import accum_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] acc_res,
    output logic [WIDTH-1:0] flag_res,
    output logic             cout
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] ax, bx, cx, wide;

    assign ax = {1'b0, a};
    assign bx = {1'b0, b};
    assign cx = {{WIDTH{1'b0}}, cin};

    always_comb begin
        case (op)
            OP_ADD:  wide = ax + bx;
            OP_ADC:  wide = ax + bx + cx;
            OP_SUB:  wide = ax - bx;
            OP_SBB:  wide = ax - bx - cx;
            OP_AND:  wide = ax & bx;
            OP_XOR:  wide = ax ^ bx;
            OP_OR:   wide = ax | bx;
            default: wide = ax - bx;
        endcase
    end

    // bit WIDTH is carry after add, borrow after subtract, 0 after logic ops
    assign cout     = wide[WIDTH];
    assign flag_res = wide[WIDTH-1:0];
    assign acc_res  = (op == OP_CMP) ? a : wide[WIDTH-1:0];
endmodule

// File: rtl/alu_rot.sv
module alu_rot
    import accum_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  rot_e             sel,
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        case (sel)
            ROT_LEFT_COPY: begin
                res  = {a[MSB-1:0], a[MSB]};
                cout = a[MSB];
            end
            ROT_RIGHT_COPY: begin
                res  = {a[0], a[MSB:1]};
                cout = a[0];
            end
            ROT_LEFT_THRU: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            default: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
        endcase
    end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import accum_alu_pkg::*;
(
    input  flags_t     flags,
    input  logic [2:0] code,
    output logic       hit
);
    // top bit asks for the flag being set, low bits name the flag
    assign hit = ~(code[2] ^ pick_flag(flags, code[1:0]));
endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_alu_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter bit REG_FLAGS = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_rot,
    input  logic [2:0]       alu_code,
    input  logic [1:0]       rot_sel,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] opnd_in,
    input  logic [3:0]       flags_in,
    input  logic [2:0]       cond_code,
    input  logic             flag_we,
    output logic [WIDTH-1:0] acc_out,
    output logic [3:0]       flags_new,
    output logic [3:0]       flags_q,
    output logic             cond_true
);
    flags_t           cur, nxt;
    logic [WIDTH-1:0] ar_acc, ar_flag, rt_res;
    logic             ar_cout, rt_cout;

    assign cur = flags_t'(flags_in);

    alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op       (alu_op_e'(alu_code)),
        .a        (acc_in),
        .b        (opnd_in),
        .cin      (cur.cy),
        .acc_res  (ar_acc),
        .flag_res (ar_flag),
        .cout     (ar_cout)
    );

    alu_rot #(.WIDTH(WIDTH)) u_rot (
        .sel  (rot_e'(rot_sel)),
        .a    (acc_in),
        .cin  (cur.cy),
        .res  (rt_res),
        .cout (rt_cout)
    );

    alu_cond u_cond (
        .flags (cur),
        .code  (cond_code),
        .hit   (cond_true)
    );

    always_comb begin
        if (is_rot) begin
            acc_out = rt_res;
            nxt     = cur;
            nxt.cy  = rt_cout;
        end else begin
            acc_out = ar_acc;
            nxt.sg  = ar_flag[WIDTH-1];
            nxt.zr  = (ar_flag == '0);
            nxt.pe  = ~^ar_flag;
            nxt.cy  = ar_cout;
        end
    end

    assign flags_new = nxt;

    generate
        if (REG_FLAGS) begin : g_flag_reg
            flags_t held;
            always_ff @(posedge clk) begin
                if (rst)          held <= '0;
                else if (flag_we) held <= nxt;
            end
            assign flags_q = held;
        end else begin : g_flag_thru
            assign flags_q = nxt;
        end
    endgenerate
endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk #(
    parameter int WIDTH     = 8,
    parameter bit REG_FLAGS = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             is_rot,
    input logic [2:0]       alu_code,
    input logic [1:0]       rot_sel,
    input logic [WIDTH-1:0] acc_in,
    input logic [3:0]       flags_in,
    input logic [2:0]       cond_code,
    input logic             flag_we,
    input logic [WIDTH-1:0] acc_out,
    input logic [3:0]       flags_new,
    input logic [3:0]       flags_q,
    input logic             cond_true
);
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (!is_rot && alu_code == 3'b111) |-> acc_out == acc_in); // R3

    AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (rst)
        (!is_rot && alu_code[2] && alu_code != 3'b111) |-> !flags_new[0]); // R2

    AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (rst)
        (!is_rot && alu_code != 3'b111) |-> flags_new[2] == (acc_out == '0)); // R5

    AST_ROT_KEEPS_SZP: assert property (@(posedge clk) disable iff (rst)
        is_rot |-> flags_new[3:1] == flags_in[3:1]); // R8

    AST_ROT_LEFT_CY: assert property (@(posedge clk) disable iff (rst)
        (is_rot && !rot_sel[0]) |-> flags_new[0] == acc_in[WIDTH-1]); // R6

    AST_COND_ZERO_TRUE: assert property (@(posedge clk) disable iff (rst)
        (cond_code == 3'b101) |-> cond_true == flags_in[2]); // R9

    generate
        if (REG_FLAGS) begin : g_reg_chk
            AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
                flag_we |=> flags_q == $past(flags_new)); // R10

            AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
                !flag_we |=> $stable(flags_q)); // R10
        end
    endgenerate
endmodule

bind accum_alu accum_alu_chk #(.WIDTH(WIDTH), .REG_FLAGS(REG_FLAGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .is_rot    (is_rot),
    .alu_code  (alu_code),
    .rot_sel   (rot_sel),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .cond_code (cond_code),
    .flag_we   (flag_we),
    .acc_out   (acc_out),
    .flags_new (flags_new),
    .flags_q   (flags_q),
    .cond_true (cond_true)
);

// File: tb/sim_accum_alu.sv
module sim_accum_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       is_rot = 1'b0;
    logic [2:0] alu_code = '0;
    logic [1:0] rot_sel = '0;
    logic [7:0] acc_in = '0, opnd_in = '0;
    logic [3:0] flags_in = '0;
    logic [2:0] cond_code = '0;
    logic       flag_we = 1'b0;
    logic [7:0] acc_out;
    logic [3:0] flags_new, flags_q;
    logic       cond_true;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    accum_alu u0 (
        .clk(clk), .rst(rst), .is_rot(is_rot), .alu_code(alu_code),
        .rot_sel(rot_sel), .acc_in(acc_in), .opnd_in(opnd_in),
        .flags_in(flags_in), .cond_code(cond_code), .flag_we(flag_we),
        .acc_out(acc_out), .flags_new(flags_new), .flags_q(flags_q),
        .cond_true(cond_true)
    );

    // flag vectors: {sign, zero, parity, carry}
    typedef struct packed {
        logic [3:0] req;
        logic       rot;
        logic [2:0] code;
        logic [7:0] a;
        logic [7:0] b;
        logic [3:0] fin;
        logic [7:0] eacc;
        logic [3:0] efl;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [0:NV-1] = '{
        '{4'd5, 1'b0, 3'd0, 8'h3C, 8'h44, 4'h0, 8'h80, 4'h8}, // R5 add, sign, odd parity
        '{4'd4, 1'b0, 3'd0, 8'hFF, 8'h01, 4'h0, 8'h00, 4'h7}, // R4 add wraps with carry
        '{4'd1, 1'b0, 3'd1, 8'h10, 8'h20, 4'h1, 8'h31, 4'h0}, // R1 add with carry-in
        '{4'd4, 1'b0, 3'd1, 8'hFF, 8'h00, 4'h1, 8'h00, 4'h7}, // R4 carry-in ripples out
        '{4'd4, 1'b0, 3'd2, 8'h05, 8'h07, 4'h0, 8'hFE, 4'h9}, // R4 subtract borrows
        '{4'd1, 1'b0, 3'd3, 8'h05, 8'h05, 4'h1, 8'hFF, 4'hB}, // R1 subtract with borrow-in
        '{4'd1, 1'b0, 3'd2, 8'h42, 8'h02, 4'h0, 8'h40, 4'h0}, // R1 plain subtract
        '{4'd2, 1'b0, 3'd4, 8'hF0, 8'h3C, 4'h1, 8'h30, 4'h2}, // R2 AND clears carry
        '{4'd2, 1'b0, 3'd5, 8'hAA, 8'hAA, 4'hF, 8'h00, 4'h6}, // R2 XOR to zero
        '{4'd2, 1'b0, 3'd6, 8'h01, 8'h80, 4'h1, 8'h81, 4'hA}, // R2 OR
        '{4'd3, 1'b0, 3'd7, 8'h10, 8'h20, 4'h0, 8'h10, 4'hB}, // R3 compare below
        '{4'd3, 1'b0, 3'd7, 8'h33, 8'h33, 4'h0, 8'h33, 4'h6}, // R3 compare equal
        '{4'd6, 1'b1, 3'd0, 8'h81, 8'h00, 4'h0, 8'h03, 4'h1}, // R6 left copy
        '{4'd6, 1'b1, 3'd1, 8'h01, 8'h00, 4'hE, 8'h80, 4'hF}, // R6 right copy, R8 keeps SZP
        '{4'd7, 1'b1, 3'd2, 8'h80, 8'h00, 4'h0, 8'h00, 4'h1}, // R7 left through, carry 0 in
        '{4'd7, 1'b1, 3'd2, 8'h40, 8'h00, 4'h1, 8'h81, 4'h0}, // R7 left through, carry 1 in
        '{4'd8, 1'b1, 3'd3, 8'h01, 8'h00, 4'h6, 8'h00, 4'h7}, // R8 right through keeps Z,P
        '{4'd7, 1'b1, 3'd3, 8'h02, 8'h00, 4'h9, 8'h81, 4'h8}  // R7 right through, carry 1 in
    };

    task automatic check4(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10 reset clears the flag register
        check4("R10 reset flags_q", {4'h0, flags_q}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            is_rot   = VEC[i].rot;
            alu_code = VEC[i].code;
            rot_sel  = VEC[i].code[1:0];
            acc_in   = VEC[i].a;
            opnd_in  = VEC[i].b;
            flags_in = VEC[i].fin;
            @(negedge clk);
            check4($sformatf("R%0d vec%0d acc", VEC[i].req, i), acc_out, VEC[i].eacc);
            check4($sformatf("R%0d vec%0d flags", VEC[i].req, i), {4'h0, flags_new}, {4'h0, VEC[i].efl});
        end

        // R9 sweep every condition code against every flag pattern
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] fv;
                logic       pick, exp;
                fv = 4'(f);
                case (c % 4)
                    0: pick = fv[0];
                    1: pick = fv[2];
                    2: pick = fv[3];
                    default: pick = fv[1];
                endcase
                exp = (c >= 4) ? pick : !pick;
                cond_code = 3'(c);
                flags_in  = fv;
                #1;
                check4($sformatf("R9 cond=%0d flags=%h", c, fv), {7'h0, cond_true}, {7'h0, exp});
            end
        end

        // R10 load on enable: add FF+01 gives flags 0111
        @(negedge clk);
        is_rot = 1'b0; alu_code = 3'd0; acc_in = 8'hFF; opnd_in = 8'h01; flags_in = 4'h0;
        flag_we = 1'b1;
        @(negedge clk);
        check4("R10 load flags_q", {4'h0, flags_q}, 8'h07);

        // R10 hold without enable while the operation changes
        flag_we = 1'b0; alu_code = 3'd6; acc_in = 8'h01; opnd_in = 8'h80;
        @(negedge clk);
        check4("R10 hold flags_q", {4'h0, flags_q}, 8'h07);
        check4("R2 OR flags while held", {4'h0, flags_new}, 8'h0A);

        // R10 reset while the enable is high still clears
        flag_we = 1'b1; rst = 1'b1;
        @(negedge clk);
        check4("R10 reset over load", {4'h0, flags_q}, 8'h00);
        rst = 1'b0; flag_we = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule